// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

The block collects up to eight interrupt requests, ranks them by a fixed priority and raises one interrupt line towards a processor. When the processor acknowledges, the block hands back an 8-bit vector: a programmable base plus the number of the winning line. It also records that line as in service until software ends it. Software reaches the block through a byte-wide port with two addresses. One address takes commands and returns the request or in-service register. The other takes configuration bytes during start-up and holds the mask register the rest of the time.

Start-up is a fixed sequence. A command byte with bit 4 set opens it, and the next three data-address writes supply the vector base, a cascade configuration byte and a mode byte. The cascade byte is only kept and shown on an output, because no multi-chip signalling takes place. The mode byte can select automatic end-of-interrupt, so that an acknowledged line never stays in service. Each input is set to edge or level triggering by a configuration input. An acknowledge that finds no request it can forward still produces a vector, the one for level 7, and leaves the in-service register unchanged.

Top module: `pic_core`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers are 0, command-address reads return the request register, and `int_out` and `vec_valid` are low.
- R2: A command write with bit 4 set (for example 0x11) starts initialization; the next three data-address writes load, in order, the vector base, the cascade byte (shown on `cascade_cfg`) and the mode byte, whose bit 1 selects automatic end-of-interrupt. These writes leave the mask unchanged.
- R3: Outside initialization a data-address write loads the mask and a data-address read returns it; a mask bit of 1 blocks that line, so a mask of 0xFF keeps `int_out` low.
- R4: With `trig_level[n]`=1, request bit n copies input n one clock later. With `trig_level[n]`=0, a rising edge on input n sets request bit n, and the bit stays set until line n is acknowledged.
- R5: `int_out` is high exactly when there is an unmasked request bit, the lowest-numbered such bit is n, and no in-service bit numbered n or lower is set (line 0 has the highest priority).
- R6: A one-cycle pulse on `inta` while line n is forwarded gives, one clock later, a one-cycle `vec_valid` with `vec_out` = base + n (modulo 256), sets in-service bit n and clears edge request bit n.
- R7: A command write of 0x60+n (n 0..7, bits 7:5 = 011, bits 4:3 = 00) clears in-service bit n and leaves the other in-service bits as they were.
- R8: A command write of 0x0A makes later command-address reads return the request register, and 0x0B the in-service register (bit 3 = 1 marks this command, bit 1 enables the choice and bit 0 picks the in-service register). Starting initialization brings the choice back to the request register and clears the in-service register.
- R9: With automatic end-of-interrupt selected, an acknowledge returns the same vector as in R6 but leaves the in-service register unchanged.
- R10: An acknowledge while no line is forwarded returns base + 7 with `vec_valid`, and leaves the in-service register unchanged. This holds even when line 7 is masked or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | 0 selects the command address, 1 the data (mask) address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is 0 while it is low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_in | input | 8 | Interrupt request inputs, line 0 highest priority |
| trig_level | input | 8 | Per-line trigger choice, 1 = level, 0 = rising edge |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Acknowledge pulse from the processor |
| vec_out | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking a new `vec_out` |
| cascade_cfg | output | 8 | Stored cascade configuration byte |

## Verification
Directed cases come first. A single edge pulse shows that a request is latched and held after its input falls. A level line that drops shows that the request follows the input. Two requests are ended one at a time, which shows that an in-service line blocks a lower one until its end-of-interrupt arrives. An empty acknowledge and one against a masked line 7 separate the spurious path from a real grant, and a second start-up with automatic end-of-interrupt shows that the in-service register is left untouched. A long stream with a fixed seed then mixes input toggles, acknowledges, end-of-interrupts, mask and trigger changes and restarts. A bench model tracks the interrupt line, the vectors and every readback, which exposes ordering faults between the request, mask and in-service registers.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES = 8;
  localparam int PIC_DW    = 8;
  localparam int PIC_LVL_W = $clog2(PIC_LINES);

  typedef logic [PIC_LINES-1:0] line_vec_t;
  typedef logic [PIC_LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {SEQ_RUN, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_t;

  typedef struct packed {
    logic hit;
    lvl_t lvl;
  } pick_t;

  localparam logic [2:0] OCW2_SPECIFIC = 3'b011;

  // Lowest-numbered set bit, i.e. the highest priority line.
  function automatic pick_t lowest_set(line_vec_t v);
    pick_t p;
    p = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.lvl = lvl_t'(i);
      end
    end
    return p;
  endfunction

  // Lines of equal or higher priority than l.
  function automatic line_vec_t upto_mask(lvl_t l);
    line_vec_t m;
    for (int i = 0; i < PIC_LINES; i++) m[i] = (i <= int'(l));
    return m;
  endfunction

  function automatic line_vec_t one_hot(lvl_t l);
    return line_vec_t'(1) << l;
  endfunction

  function automatic logic [PIC_DW-1:0] vector_for(logic [PIC_DW-1:0] base, lvl_t l);
    return base + PIC_DW'(l);
  endfunction
endpackage

// File: rtl/pic_ctl.sv
module pic_ctl
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [PIC_DW-1:0] bus_wdata,
  output line_vec_t         imr,
  output logic [PIC_DW-1:0] base,
  output logic [PIC_DW-1:0] casc,
  output logic              aeoi,
  output logic              rd_isr,
  output logic              icw1_hit,
  output logic              eoi_hit,
  output lvl_t              eoi_lvl
);
  seq_t seq_q;
  logic cmd_wr, dat_wr, ocw3_hit;

  assign cmd_wr   = bus_wr && !bus_addr;
  assign dat_wr   = bus_wr && bus_addr;
  assign icw1_hit = cmd_wr && bus_wdata[4];
  assign ocw3_hit = cmd_wr && !bus_wdata[4] && bus_wdata[3];
  assign eoi_hit  = cmd_wr && !bus_wdata[4] && !bus_wdata[3] &&
                    (bus_wdata[7:5] == OCW2_SPECIFIC);
  assign eoi_lvl  = bus_wdata[PIC_LVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= SEQ_RUN;
      imr    <= '1;
      base   <= '0;
      casc   <= '0;
      aeoi   <= 1'b0;
      rd_isr <= 1'b0;
    end else begin
      if (icw1_hit) begin
        seq_q  <= SEQ_BASE;
        rd_isr <= 1'b0;
      end else if (ocw3_hit && bus_wdata[1]) begin
        rd_isr <= bus_wdata[0];
      end
      if (dat_wr) begin
        unique case (seq_q)
          SEQ_RUN:  imr <= line_vec_t'(bus_wdata);
          SEQ_BASE: begin base <= bus_wdata; seq_q <= SEQ_CASC; end
          SEQ_CASC: begin casc <= bus_wdata; seq_q <= SEQ_MODE; end
          SEQ_MODE: begin aeoi <= bus_wdata[1]; seq_q <= SEQ_RUN; end
          default:  seq_q <= SEQ_RUN;
        endcase
      end
    end
  end

  // R2: the base byte is the first data write of the sequence
  a_r2_base_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && seq_q == SEQ_BASE) |=> (seq_q == SEQ_CASC && base == $past(bus_wdata)))
    else $error("a_r2_base_step");
  a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != SEQ_RUN) |=> $stable(imr))
    else $error("a_r2_mask_kept");
  a_r8_restart_sel: assert property (@(posedge clk) disable iff (!rst_n)
    icw1_hit |=> (!rd_isr && seq_q == SEQ_BASE))
    else $error("a_r8_restart_sel");
endmodule

// File: rtl/pic_irr.sv
module pic_irr
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  line_vec_t trig_level,
  input  line_vec_t clr_mask,
  output line_vec_t irr
);
  line_vec_t prev_q, irr_q, rise, irr_d;

  assign rise = irq_in & ~prev_q;

  for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
    always_comb begin
      if (trig_level[g]) irr_d[g] = irq_in[g];
      else               irr_d[g] = (irr_q[g] && !clr_mask[g]) || rise[g];
    end

    // R4: edge request held until its own acknowledge
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[g] && irr_q[g] && !clr_mask[g]) |=> irr_q[g])
      else $error("a_r4_edge_hold");
    a_r4_level_track: assert property (@(posedge clk) disable iff (!rst_n)
      trig_level[g] |=> (irr_q[g] == $past(irq_in[g])))
      else $error("a_r4_level_track");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/pic_prio.sv
module pic_prio
  import pic_pkg::*;
(
  input  line_vec_t irr,
  input  line_vec_t imr,
  input  line_vec_t isr,
  output logic      fwd,
  output lvl_t      lvl
);
  pick_t     pick;
  line_vec_t pend;
  logic      blocked;

  always_comb begin
    pend    = irr & ~imr;
    pick    = lowest_set(pend);
    blocked = |(isr & upto_mask(pick.lvl));
    fwd     = pick.hit && !blocked;
    lvl     = pick.lvl;
  end
endmodule

// File: rtl/pic_svc.sv
module pic_svc
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta,
  input  logic              fwd,
  input  lvl_t              lvl,
  input  logic [PIC_DW-1:0] base,
  input  logic              aeoi,
  input  logic              icw1_hit,
  input  logic              eoi_hit,
  input  lvl_t              eoi_lvl,
  output line_vec_t         isr,
  output line_vec_t         irr_clr,
  output logic [PIC_DW-1:0] vec_out,
  output logic              vec_valid
);
  line_vec_t isr_q, set_mask, eoi_mask;
  logic ack_real, ack_spur, eoi_clash;
  logic [PIC_DW-1:0] vec_q;
  logic vv_q;

  assign ack_real  = inta && fwd;
  assign ack_spur  = inta && !fwd;
  assign set_mask  = (ack_real && !aeoi) ? one_hot(lvl) : '0;
  assign eoi_mask  = eoi_hit ? one_hot(eoi_lvl) : '0;
  assign irr_clr   = ack_real ? one_hot(lvl) : '0;
  assign eoi_clash = ack_real && (lvl == eoi_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      vec_q <= '0;
      vv_q  <= 1'b0;
    end else begin
      if (icw1_hit) isr_q <= '0;
      else          isr_q <= (isr_q & ~eoi_mask) | set_mask;
      vv_q <= inta;
      if (inta) vec_q <= vector_for(base, ack_real ? lvl : lvl_t'('1));
    end
  end

  assign isr       = isr_q;
  assign vec_out   = vec_q;
  assign vec_valid = vv_q;

  // R6: new in-service bits only follow an acknowledge
  a_r6_isr_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_q & ~$past(isr_q))) |-> $past(inta))
    else $error("a_r6_isr_from_ack");
  a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q |-> $past(inta))
    else $error("a_r6_strobe_cause");
  a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !eoi_clash) |=> !isr_q[$past(eoi_lvl)])
    else $error("a_r7_eoi_clears");
  a_r9_auto_end: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi && !eoi_hit && !icw1_hit) |=> $stable(isr_q))
    else $error("a_r9_auto_end");
  a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_spur && !eoi_hit && !icw1_hit) |=> ($stable(isr_q) && vv_q))
    else $error("a_r10_spurious");
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PIC_DW-1:0] bus_wdata,
  output logic [PIC_DW-1:0] bus_rdata,
  input  line_vec_t         irq_in,
  input  line_vec_t         trig_level,
  output logic              int_out,
  input  logic              inta,
  output logic [PIC_DW-1:0] vec_out,
  output logic              vec_valid,
  output logic [PIC_DW-1:0] cascade_cfg
);
  line_vec_t imr, irr, isr, irr_clr;
  logic [PIC_DW-1:0] base;
  logic aeoi, rd_isr, icw1_hit, eoi_hit, fwd;
  lvl_t eoi_lvl, win_lvl;

  pic_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .imr(imr), .base(base), .casc(cascade_cfg),
    .aeoi(aeoi), .rd_isr(rd_isr), .icw1_hit(icw1_hit), .eoi_hit(eoi_hit),
    .eoi_lvl(eoi_lvl)
  );

  pic_irr u_irr (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_level(trig_level),
    .clr_mask(irr_clr), .irr(irr)
  );

  pic_prio u_prio (
    .irr(irr), .imr(imr), .isr(isr), .fwd(fwd), .lvl(win_lvl)
  );

  pic_svc u_svc (
    .clk(clk), .rst_n(rst_n), .inta(inta), .fwd(fwd), .lvl(win_lvl),
    .base(base), .aeoi(aeoi), .icw1_hit(icw1_hit), .eoi_hit(eoi_hit),
    .eoi_lvl(eoi_lvl), .isr(isr), .irr_clr(irr_clr), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  assign int_out = fwd;

  always_comb begin
    if (!bus_rd)       bus_rdata = '0;
    else if (bus_addr) bus_rdata = PIC_DW'(imr);
    else if (rd_isr)   bus_rdata = PIC_DW'(isr);
    else               bus_rdata = PIC_DW'(irr);
  end

  // R5: a forwarded line is pending and unmasked
  a_r5_fwd_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr[win_lvl] && !imr[win_lvl]))
    else $error("a_r5_fwd_pending");
  // R3: a full mask silences the interrupt line
  a_r3_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '1) |-> !int_out)
    else $error("a_r3_full_mask");
endmodule

// File: tb/test_pic_core.sv
`timescale 1ns/1ps
module test_pic_core;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, bus_addr, bus_wr, bus_rd, inta, int_out, vec_valid;
  logic [7:0] bus_wdata, bus_rdata, irq_in, trig_level, vec_out, cascade_cfg;

  pic_core i_pic_core (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .trig_level(trig_level), .int_out(int_out), .inta(inta), .vec_out(vec_out),
    .vec_valid(vec_valid), .cascade_cfg(cascade_cfg)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_irr = 0, m_prev = 0, m_imr = 8'hFF, m_isr = 0, m_base = 0, m_casc = 0, m_vec = 0;
  logic m_aeoi = 0, m_sel = 0, m_vv = 0, m_spur = 0;
  int m_seq = 0;

  // -1 when nothing can be forwarded
  function automatic int bench_win(logic [7:0] isr, logic [7:0] irr, logic [7:0] imr);
    logic [8:0] span;
    for (int n = 0; n < 8; n++) begin
      if (irr[n] && !imr[n]) begin
        span = (9'h2 << n) - 9'h1;
        return ((isr & span[7:0]) != 0) ? -1 : n;
      end
    end
    return -1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    int w;
    logic [7:0] rise, clr, setm, eoim, n_irr, n_isr;
    w = bench_win(m_isr, m_irr, m_imr);
    rise = irq_in & ~m_prev;
    clr = 0; setm = 0; eoim = 0;
    if (inta) begin
      if (w >= 0) begin
        m_vec = m_base + 8'(w);
        clr[w] = 1'b1;
        if (!m_aeoi) setm[w] = 1'b1;
        m_spur = 0;
      end else begin
        m_vec = m_base + 8'd7;
        m_spur = 1;
      end
    end
    n_isr = m_isr;
    if (bus_wr && !bus_addr) begin
      if (bus_wdata[4]) begin m_seq = 1; m_sel = 0; end
      else if (bus_wdata[3]) begin if (bus_wdata[1]) m_sel = bus_wdata[0]; end
      else if (bus_wdata[7:5] == 3'b011) eoim[bus_wdata[2:0]] = 1'b1;
    end
    n_isr = (n_isr & ~eoim) | setm;
    if (bus_wr && !bus_addr && bus_wdata[4]) n_isr = 0;
    if (bus_wr && bus_addr) begin
      case (m_seq)
        0: m_imr = bus_wdata;
        1: begin m_base = bus_wdata; m_seq = 2; end
        2: begin m_casc = bus_wdata; m_seq = 3; end
        default: begin m_aeoi = bus_wdata[1]; m_seq = 0; end
      endcase
    end
    for (int i = 0; i < 8; i++)
      n_irr[i] = trig_level[i] ? irq_in[i] : ((m_irr[i] && !clr[i]) || rise[i]);
    @(posedge clk);
    m_irr = n_irr; m_prev = irq_in; m_isr = n_isr; m_vv = inta;
    @(negedge clk);
    check("R5 int_out", 8'(int_out), 8'(bench_win(m_isr, m_irr, m_imr) >= 0));
    check("R6 vec_valid", 8'(vec_valid), 8'(m_vv));
    if (m_vv) check(m_spur ? "R10 spurious vector" : "R6 vector", vec_out, m_vec);
  endtask

  task automatic do_wr(logic a, logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic do_ack();
    inta = 1; tick(); inta = 0;
  endtask

  task automatic read_chk(logic a, string tag);
    logic [7:0] exp;
    exp = a ? m_imr : (m_sel ? m_isr : m_irr);
    bus_addr = a; bus_rd = 1;
    #1;
    check(tag, bus_rdata, exp);
    bus_rd = 0;
  endtask

  task automatic pulse_line(int n);
    irq_in[n] = 1; tick(); irq_in[n] = 0; tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    void'($urandom(32'd4242));
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    irq_in = 0; trig_level = 0; inta = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 int_out", 8'(int_out), 8'h0);
    check("R1 vec_valid", 8'(vec_valid), 8'h0);
    read_chk(1, "R1 mask reset");
    read_chk(0, "R1 request reset");
    do_wr(0, 8'h0B); read_chk(0, "R1 service reset");
    do_wr(0, 8'h0A);
    // R2 init sequence
    do_wr(0, 8'h11); do_wr(1, 8'h20); do_wr(1, 8'h04); do_wr(1, 8'h01);
    check("R2 cascade byte", cascade_cfg, 8'h04);
    read_chk(1, "R2 mask untouched");
    // R3 mask load
    do_wr(1, 8'h00); read_chk(1, "R3 mask readback");
    // R4 edge latch held
    pulse_line(5); read_chk(0, "R4 edge held");
    do_ack();
    read_chk(0, "R6 edge cleared");
    do_wr(0, 8'h0B); read_chk(0, "R8 service select");
    do_wr(0, 8'h65); read_chk(0, "R7 specific end");
    // R5 priority blocking
    irq_in = 8'h0C; tick(); irq_in = 0; tick();
    do_ack();
    check("R5 blocked by service", 8'(int_out), 8'h0);
    do_wr(0, 8'h62);
    check("R5 released", 8'(int_out), 8'h1);
    do_ack(); do_wr(0, 8'h63);
    // R10 spurious
    do_ack(); read_chk(0, "R10 service unchanged");
    do_wr(1, 8'h80); pulse_line(7); do_ack();
    read_chk(0, "R10 masked seven");
    // R4 level follow
    do_wr(0, 8'h0A);
    trig_level = 8'h02; irq_in[1] = 1; tick(); read_chk(0, "R4 level high");
    irq_in[1] = 0; tick(); read_chk(0, "R4 level low");
    trig_level = 0;
    // R9 automatic end
    do_wr(0, 8'h11); do_wr(1, 8'h40); do_wr(1, 8'h00); do_wr(1, 8'h03);
    do_wr(1, 8'h00); pulse_line(3); do_ack();
    do_wr(0, 8'h0B); read_chk(0, "R9 nothing in service");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      r = $urandom_range(0, 19);
      case (r)
        0, 1, 2, 3, 4, 5: begin irq_in = irq_in ^ (8'h1 << $urandom_range(0, 7)); tick(); end
        6, 7, 8: do_ack();
        9, 10: do_wr(0, 8'h60 | 8'($urandom_range(0, 7)));
        11: do_wr(1, 8'($urandom) & 8'($urandom));
        12: do_wr(0, 8'h0A | 8'($urandom_range(0, 1)));
        13: read_chk(0, "R8 random readback");
        14: read_chk(1, "R3 random readback");
        15: begin trig_level = 8'($urandom); tick(); end
        16: if ($urandom_range(0, 9) == 0) begin
              do_wr(0, 8'h11); do_wr(1, 8'($urandom)); do_wr(1, 8'($urandom));
              do_wr(1, 8'($urandom));
              check("R2 cascade random", cascade_cfg, m_casc);
            end else tick();
        default: tick();
      endcase
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule